// File: doc/BRIEF.md
# Double-Data-Rate SPI Master with Delayed Capture

This block is the controller end of a four-wire serial link to a multi-channel acquisition front end. For each frame it lowers chip select, shifts out one 16-bit command on MOSI with the most significant bit first, and toggles SCLK sixteen times. The slave returns two 16-bit results on one MISO wire at double data rate. The master samples MISO at every SCLK falling edge, at every SCLK rising edge, and once more when chip select goes high. It sorts those samples into two words, A and B.

All link timing comes from a fast system clock. The SCLK half period, the chip-select lead and trail times and the gap between frames are whole numbers of system-clock cycles. A long cable delays the returning data by the round trip. A programmable delay of 0 to 15 system-clock cycles therefore moves every MISO sample point later by the same amount. The delay value is latched when a frame starts. When the last sample is taken, both words are presented together with a one-cycle done strobe.

Top module: `ddr_spi_master`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` is 1, `sclk` is 0 and `done` is 0. `sclk` is never high while `cs_n` is high.
- R2: During a frame, the 16 bits of `cmd` appear on `mosi` MSB first, one bit per SCLK rising edge. A bit is stable for the whole SCLK high phase and changes only after a falling edge.
- R3: Each SCLK high phase and each SCLK low phase between two rising edges lasts HALF system-clock cycles (default 3). Every frame has exactly 16 rising edges and 16 falling edges.
- R4: From the fall of `cs_n` to the first SCLK rise there are LEAD cycles (default 3). From the last SCLK fall to the rise of `cs_n` there are HALF+TRAIL cycles (default 4).
- R5: Between frames, `cs_n` stays high for at least the larger of GAP and 2^DLY_W cycles (default 16).
- R6: `word_a` is built from the 16 MISO samples taken at the SCLK falling edges. The first sample is bit 15 and the last is bit 0.
- R7: The sample at the first SCLK rising edge is dropped. The samples at rising edges 2 to 16 become `word_b` bits 15 down to 1, and the sample at the `cs_n` rising edge becomes bit 0.
- R8: Each sample is taken `sample_dly` system-clock cycles later than the undelayed sample point of its edge. The value of `sample_dly` is latched at frame start.
- R9: `done` is high for exactly one cycle. Count the first cycle with `cs_n` high as cycle 1; `done` is then high in cycle `sample_dly`+2. `word_a` and `word_b` change only in the cycle where `done` is high, and hold their values otherwise.
- R10: A `start` pulse is ignored while a frame is running and while the between-frame gap is running. It causes no `cs_n` fall and does not change the command being sent.
- R11: From one fall of `cs_n` to the next there are at least MIN_PERIOD cycles (default 95). The gap is stretched when needed to meet this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request; used only when the master is idle |
| cmd | input | 16 | Command word to send, latched at start |
| sample_dly | input | 4 | MISO sample delay in system clocks, latched at start |
| miso | input | 1 | Returned double-data-rate serial data |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, low when idle |
| mosi | output | 1 | Serial command data |
| word_a | output | 16 | Word built from falling-edge samples |
| word_b | output | 16 | Word built from rising-edge samples and the chip-select rise sample |
| done | output | 1 | One-cycle strobe when both words are updated |

## Verification
The bench models a slave that drives MISO through a cable delay of 2 to 15 cycles. The bench sets the sample delay to match that cable delay. A master that samples at the wrong point, or ignores the delay, returns words shifted by a bit or mixed between A and B. Directed frames use all-zero, all-one and alternating patterns. The slave outputs a 1 before the first rising edge, so a B word of zero shows at once if the first rising-edge sample is kept instead of dropped, or if the chip-select-rise sample is lost. Start pulses are also issued in the middle of a frame and during the gap. A master that accepts them would restart chip select early or corrupt the command being sent.

// File: rtl/ddr_spi_pkg.sv
// Shared types for the double-data-rate SPI master.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ddr_spi_pkg;

    // Sample-point tags carried from the timing generator to the capture unit.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2,
        EV_CSUP = 2'd3
    } spi_ev_e;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_CLK   = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } spi_st_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_spi_timing.sv
// Frame sequencer: drives cs_n, sclk and mosi, and tags each sample point.
// Assumes: HALF, LEAD and TRAIL are all at least 1. The gap is stretched so
// that the sample delay line drains before the next frame, and so that the
// frame period meets MIN_PERIOD.
module ddr_spi_timing
    import ddr_spi_pkg::*;
#(
    parameter int HALF       = 3,
    parameter int LEAD       = 3,
    parameter int TRAIL      = 1,
    parameter int GAP        = 16,
    parameter int MIN_PERIOD = 95,
    parameter int CMD_W      = 16,
    parameter int DLY_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DLY_W-1:0] dly_in,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output spi_ev_e          ev,
    output logic [DLY_W-1:0] dly_q
);
    localparam int BODY    = LEAD + 2 * HALF * CMD_W + TRAIL;
    localparam int GAP_EFF = imax(imax(GAP, 2 ** DLY_W), MIN_PERIOD - BODY);
    localparam int CMAX    = imax(imax(LEAD, TRAIL), imax(GAP_EFF, 2 * HALF));
    localparam int CW      = $clog2(CMAX + 1);
    localparam int BW      = $clog2(CMD_W);
    localparam int GW      = $clog2(GAP_EFF + 1);
    localparam int PW      = $clog2(MIN_PERIOD + 1);

    spi_st_e          state;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [CMD_W-1:0] shreg;

    // Sequencer: walks lead, sixteen clock bits, trail and gap; tags each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            cs_n  <= 1'b1;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            ev    <= EV_NONE;
            dly_q <= '0;
        end else begin
            ev <= EV_NONE;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LEAD;
                        cnt   <= '0;
                        cs_n  <= 1'b0;
                        shreg <= cmd;
                        mosi  <= cmd[CMD_W-1];
                        dly_q <= dly_in;
                    end
                end
                ST_LEAD: begin
                    if (cnt == CW'(LEAD - 1)) begin
                        state <= ST_CLK;
                        cnt   <= '0;
                        bitn  <= '0;
                        sclk  <= 1'b1;
                        ev    <= EV_RISE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CLK: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(HALF - 1)) begin
                        sclk  <= 1'b0;
                        ev    <= EV_FALL;
                        shreg <= {shreg[CMD_W-2:0], 1'b0};
                        mosi  <= shreg[CMD_W-2];
                    end else if (cnt == CW'(2 * HALF - 1)) begin
                        cnt <= '0;
                        if (bitn == BW'(CMD_W - 1)) begin
                            state <= ST_TRAIL;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sclk <= 1'b1;
                            ev   <= EV_RISE;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (cnt == CW'(TRAIL - 1)) begin
                        state <= ST_GAP;
                        cnt   <= '0;
                        cs_n  <= 1'b1;
                        mosi  <= 1'b0;
                        ev    <= EV_CSUP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == CW'(GAP_EFF - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: length of the high phase, the gap and the frame period.
    logic [CW-1:0] hi_run;
    logic [GW-1:0] gap_run;
    logic [PW-1:0] per_run;
    logic          cs_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            gap_run <= GW'(GAP_EFF);
            per_run <= PW'(MIN_PERIOD);
            cs_prev <= 1'b1;
        end else begin
            cs_prev <= cs_n;
            hi_run  <= sclk ? hi_run + 1'b1 : '0;
            if (!cs_n)
                gap_run <= '0;
            else if (gap_run != GW'(GAP_EFF))
                gap_run <= gap_run + 1'b1;
            if (cs_prev && !cs_n)
                per_run <= PW'(1);
            else if (per_run != PW'(MIN_PERIOD))
                per_run <= per_run + 1'b1;
        end
    end

    assert_sclk_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_run == CW'(HALF));
    assert_gap_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> gap_run == GW'(GAP_EFF));
    assert_start_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(state) == ST_IDLE);
    assert_frame_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_prev && !cs_n) |-> per_run == PW'(MIN_PERIOD));

endmodule

// File: rtl/ddr_spi_evdelay.sv
// Delay line for sample-point tags: passes each tag on after a selectable
// number of system clocks. Tap 0 is the undelayed tag.
// Assumes: sel stays constant while tags are in flight.
module ddr_spi_evdelay
    import ddr_spi_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spi_ev_e          ev_in,
    input  logic [DLY_W-1:0] sel,
    output spi_ev_e          ev_out
);
    localparam int DEPTH = 2 ** DLY_W;

    logic [DEPTH-1:0][1:0] taps;
    assign taps[0] = ev_in;

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        logic [1:0] q;
        // One stage of the tag pipeline.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= EV_NONE;
            else        q <= taps[i-1];
        end
        assign taps[i] = q;
    end

    assign ev_out = spi_ev_e'(taps[sel]);

endmodule

// File: rtl/ddr_spi_capture.sv
// Sorts delayed MISO samples into the A and B words. Falling-edge samples
// fill A. Rising-edge samples after the first, plus the chip-select-rise
// sample, fill B. Both words are published with a one-cycle done strobe.
// Assumes: tags arrive in frame order, with EV_CSUP last.
module ddr_spi_capture
    import ddr_spi_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  spi_ev_e      ev,
    input  logic         miso,
    output logic [W-1:0] word_a,
    output logic [W-1:0] word_b,
    output logic         done
);
    logic [W-1:0] a_sh;
    logic [W-1:0] b_sh;
    logic         rise_seen;

    // Shift the sample into the word its tag selects; publish at chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh      <= '0;
            b_sh      <= '0;
            rise_seen <= 1'b0;
            word_a    <= '0;
            word_b    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ev)
                EV_FALL: a_sh <= {a_sh[W-2:0], miso};
                EV_RISE: begin
                    if (rise_seen) b_sh <= {b_sh[W-2:0], miso};
                    else           rise_seen <= 1'b1;
                end
                EV_CSUP: begin
                    word_a    <= a_sh;
                    word_b    <= {b_sh[W-2:0], miso};
                    done      <= 1'b1;
                    rise_seen <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_csup_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_CSUP) |-> rise_seen);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_words_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(word_a) && $stable(word_b)));

endmodule

// File: rtl/ddr_spi_master.sv
// Top level of the double-data-rate SPI master: sequencer, sample delay line
// and capture unit.
// Assumes: miso is already synchronous to clk, or the cable delay covers the
// synchronizer latency.
module ddr_spi_master
    import ddr_spi_pkg::*;
#(
    parameter int HALF       = 3,
    parameter int LEAD       = 3,
    parameter int TRAIL      = 1,
    parameter int GAP        = 16,
    parameter int MIN_PERIOD = 95,
    parameter int CMD_W      = 16,
    parameter int DLY_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DLY_W-1:0] sample_dly,
    input  logic             miso,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic [CMD_W-1:0] word_a,
    output logic [CMD_W-1:0] word_b,
    output logic             done
);
    spi_ev_e          ev_now;
    spi_ev_e          ev_late;
    logic [DLY_W-1:0] dly_q;

    ddr_spi_timing #(
        .HALF(HALF), .LEAD(LEAD), .TRAIL(TRAIL), .GAP(GAP),
        .MIN_PERIOD(MIN_PERIOD), .CMD_W(CMD_W), .DLY_W(DLY_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .dly_in(sample_dly),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .ev(ev_now), .dly_q(dly_q)
    );

    ddr_spi_evdelay #(.DLY_W(DLY_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_now), .sel(dly_q), .ev_out(ev_late)
    );

    ddr_spi_capture #(.W(CMD_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .ev(ev_late), .miso(miso),
        .word_a(word_a), .word_b(word_b), .done(done)
    );

endmodule

// File: tb/ddr_spi_master_tb.sv
// Bench: a slave model with an adjustable cable lag, plus directed and seeded
// random frames.
module ddr_spi_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 3;
    localparam int LEAD = 3;
    localparam int TRAIL = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd = '0;
    logic [3:0]  sample_dly = '0;
    logic        miso = 1'b0;
    logic        cs_n, sclk, mosi, done;
    logic [15:0] word_a, word_b;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Slave model and monitor state
    logic [15:0] sl_a = '0, sl_b = '0;
    int lag = 2;
    logic hist [16];
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    int rcnt = 0, fcnt = 0, lead = 0, trail = 0, gap_cnt = 100, per = 0;
    int hi_run = 0, lo_run = 0, hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    int lat = 0, lat_done = 0, done_len = 0, frames = 0;
    bit have_prev = 1'b0;
    logic [15:0] mosi_cap = '0;
    bit mosi_bad = 1'b0;

    ddr_spi_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .sample_dly(sample_dly),
        .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .word_a(word_a), .word_b(word_b), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int exp_lat(input int d);
        return d + 2;
    endfunction

    // Slave model with cable lag, and edge monitor, evaluated away from the active edge
    always @(negedge clk) begin
        logic c;
        cycles++;
        if (!finished && cycles > 150000) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                frames++;
                check(gap_cnt >= 16, "R5 gap", gap_cnt, 16);
                if (have_prev) check(per >= 95, "R11 period", per, 95);
                have_prev = 1'b1;
                rcnt = 0; fcnt = 0; lead = 0; trail = 0; per = 0;
                hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
                mosi_cap = '0; mosi_bad = 1'b0;
            end
            per++;
            if (!prev_cs && cs_n) begin gap_cnt = 0; lat = 0; end
            if (cs_n) begin gap_cnt++; lat++; end
            if (sclk && cs_n) mosi_bad = 1'b1;
            if (!cs_n && !prev_sclk && sclk) begin
                rcnt++;
                mosi_cap = {mosi_cap[14:0], mosi};
                if (rcnt > 1) begin
                    if (lo_run < lo_min) lo_min = lo_run;
                    if (lo_run > lo_max) lo_max = lo_run;
                end
                hi_run = 0;
            end
            if (prev_sclk && !sclk) begin
                fcnt++;
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                lo_run = 0;
            end
            if (sclk && rcnt > 0 && $past(mosi) != mosi && prev_sclk) mosi_bad = 1'b1;
            if (sclk) hi_run++; else lo_run++;
            if (!cs_n && !sclk && rcnt == 0) lead++;
            if (!cs_n && !sclk && fcnt == 16) trail++;
            if (done) begin done_len++; lat_done = lat; end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
        if (cs_n) c = 1'b0;
        else if (sclk) c = (rcnt >= 1 && rcnt <= 16) ? sl_a[16 - rcnt] : 1'b0;
        else if (fcnt == 0) c = 1'b1;
        else c = sl_b[16 - fcnt];
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = c;
        miso = hist[lag];
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] c, input logic [15:0] a,
                             input logic [15:0] b, input int l);
        int d;
        int guard;
        d = (l > 3) ? l - 3 : 0;
        @(negedge clk);
        cmd = c; sl_a = a; sl_b = b; lag = l; sample_dly = 4'(d);
        done_len = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (done_len == 0 && guard < 1000) begin @(negedge clk); guard++; end
        check(word_a == a, "R6 word_a", word_a, a);
        check(word_b == b, "R7 word_b", word_b, b);
        check(mosi_cap == c && !mosi_bad, "R2 mosi", mosi_cap, c);
        check(rcnt == 16 && fcnt == 16, "R3 edge count", rcnt * 100 + fcnt, 1616);
        check(hi_min == HALF && hi_max == HALF, "R3 high phase", hi_min * 100 + hi_max, HALF * 101);
        check(lo_min == HALF && lo_max == HALF, "R3 low phase", lo_min * 100 + lo_max, HALF * 101);
        check(lead == LEAD, "R4 lead", lead, LEAD);
        check(trail == HALF + TRAIL, "R4 trail", trail, HALF + TRAIL);
        check(lat_done == exp_lat(d), "R8 R9 done latency", lat_done, exp_lat(d));
        wait_cycles(20);
        check(done_len == 1, "R9 done width", done_len, 1);
        check(word_a == a && word_b == b, "R9 words held", word_a, a);
    endtask

    initial begin
        int f0;
        for (int k = 0; k < 16; k++) hist[k] = 1'b0;
        void'($urandom(32'h5eed_1234));
        wait_cycles(3);
        check(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1 in reset",
              {cs_n, sclk, done}, 3'b100);
        rst_n = 1'b1;
        wait_cycles(4);
        check(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1 after reset",
              {cs_n, sclk, done}, 3'b100);

        // Directed patterns across the lag range
        run_frame(16'hA5C3, 16'h0000, 16'h0000, 2);
        run_frame(16'hFFFF, 16'hFFFF, 16'hFFFF, 15);
        run_frame(16'h0000, 16'h5555, 16'hAAAA, 9);
        run_frame(16'h8001, 16'h8001, 16'h0001, 3);
        run_frame(16'h7FFE, 16'h1234, 16'hFEDC, 4);

        // Start pulses during a frame and during the gap are ignored (R10)
        f0 = frames;
        @(negedge clk);
        cmd = 16'h3C3C; sl_a = 16'h0F0F; sl_b = 16'hF0F0; lag = 2; sample_dly = 4'd0;
        done_len = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_cycles(40);
        cmd = 16'hFFFF; start = 1'b1;
        @(negedge clk); start = 1'b0; cmd = 16'h3C3C;
        while (done_len == 0) @(negedge clk);
        start = 1'b1; cmd = 16'h0000;
        @(negedge clk); start = 1'b0;
        check(mosi_cap == 16'h3C3C, "R10 command unchanged", mosi_cap, 16'h3C3C);
        wait_cycles(40);
        check(frames == f0 + 1, "R10 no extra frame", frames - f0, 1);
        check(cs_n == 1'b1 && sclk == 1'b0, "R1 idle between frames", {cs_n, sclk}, 2'b10);

        // Seeded random frames
        for (int n = 0; n < 25; n++) begin
            run_frame(16'($urandom), 16'($urandom), 16'($urandom), 2 + int'($urandom % 14));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule